// File: doc/BRIEF.md
# Transmit Flow-Control Credit Gate

This block sits on the transmit side of a packet link layer. It decides whether the packet at the head of the transmit path may be sent now. The decision rests on the buffer credits that the link partner has advertised. Three packet classes are tracked: posted, non-posted and completion. Each class has a header credit and a data credit, which gives six independent credit slots. Every slot holds a wrap-around consumed counter and a limit register.

A packet needs one header unit for its class. It also needs one data unit for every started group of four payload dwords. The packet is granted only when both slots of its class have room, judged by modular comparison. On the grant cycle both counters advance. A slot whose initial advertisement is zero is treated as infinite and is never checked.

A small state machine sequences the link. In `ST_DOWN` no limits are known. The first initial-limit message moves it to `ST_LOAD`. `ST_LOAD` collects the initial limits of all three classes. Once all three have arrived, it moves to `ST_RUN`, where packets may be granted and update messages raise the limits. `ST_RUN` is left only by reset.

Top module: `fc_credit_gate`

## Requirements
- R1: After reset the state is `ST_DOWN`, `link_ready` is 0, and a valid request sees `grant`=0 and `stall`=1.
- R2: A message with `lim_kind`=1 (initial) moves `ST_DOWN` to `ST_LOAD`. When initial messages have been seen for all three classes, the state moves to `ST_RUN` and `link_ready` becomes 1. No grant is given outside `ST_RUN`. Initial messages are ignored in `ST_RUN`. Update messages (`lim_kind`=0) are ignored outside `ST_RUN`.
- R3: Each granted packet consumes exactly one header unit of its class, whatever its payload length.
- R4: A granted packet consumes ceil(`req_dw`/4) data units of its class. `req_dw`=0 consumes none.
- R5: A request is granted only if, for both the header slot and the data slot of its class, (limit − (consumed + needed)) modulo 2^W is below 2^(W−1). W is 8 for headers and 12 for data, and all counters wrap.
- R6: An initial limit of zero marks that slot as infinite. An infinite slot always passes, and later updates to it are ignored.
- R7: In `ST_RUN` an update message replaces the limits of the finite slots of its class. The new limits take effect from the next cycle.
- R8: Consumed counters change only on a cycle where `req_valid` and `grant` are both 1. A stalled request leaves them unchanged.
- R9: Class codes are 0 = posted, 1 = non-posted, 2 = completion. Exhausting one class never blocks another class.
- R10: Class code 3 is invalid. A request with class code 3 is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lim_valid | input | 1 | Limit message present this cycle |
| lim_kind | input | 1 | 1 = initial limit, 0 = update |
| lim_cls | input | 2 | Class addressed by the message |
| lim_hdr | input | 8 | Header limit value |
| lim_dat | input | 12 | Data limit value |
| req_valid | input | 1 | Packet waiting to be sent |
| req_cls | input | 2 | Class of the waiting packet |
| req_dw | input | 11 | Payload length in dwords |
| grant | output | 1 | Packet may go this cycle; counters advance |
| stall | output | 1 | Packet waiting but refused |
| link_ready | output | 1 | State is `ST_RUN` |

## Verification
The assertions watch every cycle. They check that a grant only appears in `ST_RUN` and never for class code 3, that grant and stall never coincide, and that `ST_RUN` is never left. They also check that each consumed counter either holds or steps by exactly the units requested on a grant, and that an infinite slot's limit never moves after loading. Only the bench scenarios can show the exact stall point under the modular comparison. They also show wrap-around across repeated updates, the ceil(len/4) rounding, the ignoring of messages in the wrong state, and that one class being exhausted leaves the others free.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
    localparam int NUM_CLS = 3;

    typedef enum logic [1:0] {
        CLS_POSTED = 2'd0,
        CLS_NONPOST = 2'd1,
        CLS_CPL = 2'd2,
        CLS_BAD = 2'd3
    } fc_cls_e;

    typedef enum logic [1:0] {
        ST_DOWN = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN = 2'd2
    } fc_state_e;
endpackage

// File: rtl/fcg_ctrl.sv
module fcg_ctrl
    import fcg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lim_valid,
    input  logic               lim_kind,
    input  logic [1:0]         lim_cls,
    output logic [NUM_CLS-1:0] load_en,
    output logic [NUM_CLS-1:0] upd_en,
    output logic               run
);
    fc_state_e state_q, state_d;
    logic [NUM_CLS-1:0] seen_q, seen_d;
    logic [NUM_CLS-1:0] cls_hit;
    logic init_msg, upd_msg;

    always_comb begin
        cls_hit = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            cls_hit[c] = (lim_cls == 2'(c));
        end
    end

    assign init_msg = lim_valid && lim_kind && (lim_cls != CLS_BAD);
    assign upd_msg  = lim_valid && !lim_kind && (lim_cls != CLS_BAD);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DOWN;
            seen_q  <= '0;
        end else begin
            state_q <= state_d;
            seen_q  <= seen_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        seen_d  = seen_q;
        unique case (state_q)
            ST_DOWN: begin
                if (init_msg) begin
                    seen_d  = cls_hit;
                    state_d = (&cls_hit) ? ST_RUN : ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (init_msg) begin
                    seen_d = seen_q | cls_hit;
                    if (&(seen_q | cls_hit)) begin
                        state_d = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_DOWN;
                seen_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        load_en = '0;
        upd_en  = '0;
        run     = 1'b0;
        unique case (state_q)
            ST_DOWN, ST_LOAD: begin
                if (init_msg) load_en = cls_hit;
            end
            ST_RUN: begin
                run = 1'b1;
                if (upd_msg) upd_en = cls_hit;
            end
            default: begin
                run = 1'b0;
            end
        endcase
    end

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN)); // R2
    AST_NO_LOAD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (load_en == '0)); // R2
endmodule

// File: rtl/fcg_slot.sv
module fcg_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         upd,
    input  logic [W-1:0] val,
    input  logic [W-1:0] need,
    input  logic         take,
    output logic         pass
);
    logic [W-1:0] lim_q;
    logic [W-1:0] used_q;
    logic         inf_q;
    logic [W-1:0] after;
    logic [W-1:0] gap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q  <= '0;
            used_q <= '0;
            inf_q  <= 1'b0;
        end else begin
            if (load) begin
                lim_q <= val;
                inf_q <= (val == '0);
            end else if (upd && !inf_q) begin
                lim_q <= val;
            end
            if (take) begin
                used_q <= used_q + need;
            end
        end
    end

    // modular headroom: the sign bit of the gap tells "would pass the limit"
    always_comb begin
        after = used_q + need;
        gap   = lim_q - after;
        pass  = inf_q || !gap[W-1];
    end

    AST_USED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(used_q)); // R8
    AST_USED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (used_q == W'($past(used_q) + $past(need)))); // R8
    AST_INF_LIMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (inf_q && !load) |=> $stable(lim_q)); // R6
endmodule

// File: rtl/fc_credit_gate.sv
module fc_credit_gate
    import fcg_pkg::*;
#(
    parameter int HDR_W = 8,
    parameter int DAT_W = 12,
    parameter int DW_W  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lim_valid,
    input  logic             lim_kind,
    input  logic [1:0]       lim_cls,
    input  logic [HDR_W-1:0] lim_hdr,
    input  logic [DAT_W-1:0] lim_dat,
    input  logic             req_valid,
    input  logic [1:0]       req_cls,
    input  logic [DW_W-1:0]  req_dw,
    output logic             grant,
    output logic             stall,
    output logic             link_ready
);
    localparam logic [HDR_W-1:0] HDR_NEED = HDR_W'(1);

    logic [NUM_CLS-1:0] load_en, upd_en, sel, hpass, dpass, take;
    logic               run;
    logic [DW_W:0]      dw_sum;
    logic [DAT_W-1:0]   dat_need;
    logic               cls_ok;

    fcg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .lim_valid (lim_valid),
        .lim_kind  (lim_kind),
        .lim_cls   (lim_cls),
        .load_en   (load_en),
        .upd_en    (upd_en),
        .run       (run)
    );

    // data units: started groups of four dwords
    assign dw_sum   = {1'b0, req_dw} + (DW_W+1)'(3);
    assign dat_need = DAT_W'(dw_sum[DW_W:2]);

    generate
        for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
            assign sel[c]  = (req_cls == 2'(c));
            assign take[c] = grant && sel[c];

            fcg_slot #(.W(HDR_W)) u_hdr (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (load_en[c]),
                .upd   (upd_en[c]),
                .val   (lim_hdr),
                .need  (HDR_NEED),
                .take  (take[c]),
                .pass  (hpass[c])
            );

            fcg_slot #(.W(DAT_W)) u_dat (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (load_en[c]),
                .upd   (upd_en[c]),
                .val   (lim_dat),
                .need  (dat_need),
                .take  (take[c]),
                .pass  (dpass[c])
            );
        end
    endgenerate

    assign cls_ok     = |(sel & hpass & dpass);
    assign grant      = req_valid && run && cls_ok;
    assign stall      = req_valid && !grant;
    assign link_ready = run;

    AST_GRANT_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> link_ready); // R2
    AST_BAD_CLASS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cls == CLS_BAD) |-> !grant); // R10
    AST_GRANT_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && stall)); // R8
    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take)); // R9
endmodule

// File: tb/tb_fc_credit_gate.sv
module tb_fc_credit_gate;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lim_valid = 1'b0, lim_kind = 1'b0;
    logic [1:0] lim_cls = '0;
    logic [7:0] lim_hdr = '0;
    logic [11:0] lim_dat = '0;
    logic req_valid = 1'b0;
    logic [1:0] req_cls = '0;
    logic [10:0] req_dw = '0;
    logic grant, stall, link_ready;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fc_credit_gate dut (
        .clk(clk), .rst_n(rst_n),
        .lim_valid(lim_valid), .lim_kind(lim_kind), .lim_cls(lim_cls),
        .lim_hdr(lim_hdr), .lim_dat(lim_dat),
        .req_valid(req_valid), .req_cls(req_cls), .req_dw(req_dw),
        .grant(grant), .stall(stall), .link_ready(link_ready)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic msg(input bit kind, input logic [1:0] c,
                       input logic [7:0] h, input logic [11:0] d);
        @(negedge clk);
        lim_valid = 1'b1; lim_kind = kind; lim_cls = c;
        lim_hdr = h; lim_dat = d;
        @(negedge clk);
        lim_valid = 1'b0;
    endtask

    task automatic send(input logic [1:0] c, input int n, input bit exp,
                        input string req);
        @(negedge clk);
        req_valid = 1'b1; req_cls = c; req_dw = 11'(n);
        #1;
        check(req, grant, exp);
        check(req, stall, !exp);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        req_valid = 1'b1; req_cls = 2'd0; req_dw = '0;
        #1;
        check("R1 ready", link_ready, 0);
        check("R1 grant", grant, 0);
        check("R1 stall", stall, 1);
        req_valid = 1'b0;
    endtask

    task automatic t_bringup();
        msg(1'b0, 2'd0, 8'd9, 12'd9);        // update in ST_DOWN: ignored
        check("R2 upd in down", link_ready, 0);
        msg(1'b1, 2'd0, 8'd100, 12'd0);      // posted: data infinite
        check("R2 load state", link_ready, 0);
        send(2'd0, 0, 1'b0, "R2 no grant in load");
        msg(1'b1, 2'd1, 8'd0, 12'd2000);     // non-posted: header infinite
        check("R2 still load", link_ready, 0);
        msg(1'b1, 2'd2, 8'd10, 12'd3);       // completion
        check("R2 run", link_ready, 1);
        msg(1'b1, 2'd2, 8'd0, 12'd0);        // initial in run: ignored
    endtask

    task automatic t_bad_class();
        send(2'd3, 0, 1'b0, "R10 bad class");
    endtask

    task automatic t_rounding();
        send(2'd2, 5, 1'b1, "R4 len5 two units");
        send(2'd2, 1, 1'b1, "R4 len1 one unit");
        send(2'd2, 1, 1'b0, "R4 data exhausted");
        send(2'd2, 0, 1'b1, "R4 len0 no data");
    endtask

    task automatic t_independence();
        send(2'd1, 0, 1'b1, "R9 np free while cpl data full");
    endtask

    task automatic t_header_unit();
        msg(1'b0, 2'd2, 8'd4, 12'd100);      // cpl hdr used 3, data used 3
        send(2'd2, 4, 1'b1, "R7 update raises limit");
        send(2'd2, 4, 1'b0, "R3 header one unit per packet");
        send(2'd2, 4, 1'b0, "R8 stall keeps counters");
    endtask

    task automatic t_data_wrap();
        for (int i = 0; i < 7; i++) send(2'd1, 1024, 1'b1, "R5 np data fill");
        send(2'd1, 1024, 1'b0, "R5 np data limit");
        msg(1'b0, 2'd1, 8'd5, 12'd3800);
        for (int i = 0; i < 7; i++) send(2'd1, 1024, 1'b1, "R7 np data after update");
        send(2'd1, 1024, 1'b0, "R5 np data limit 2");
        msg(1'b0, 2'd1, 8'd5, 12'd1288);     // 5384 mod 4096
        for (int i = 0; i < 7; i++) send(2'd1, 1024, 1'b1, "R5 np data wrapped");
        send(2'd1, 1024, 1'b0, "R5 np data wrapped limit");
        send(2'd1, 0, 1'b1, "R6 np header infinite");
    endtask

    task automatic t_hdr_wrap();
        for (int i = 0; i < 100; i++) send(2'd0, 0, 1'b1, "R3 posted hdr fill");
        send(2'd0, 0, 1'b0, "R5 posted hdr limit");
        msg(1'b0, 2'd0, 8'd200, 12'd5);      // data part ignored: infinite
        for (int i = 0; i < 100; i++) send(2'd0, 1024, 1'b1, "R6 posted data infinite");
        send(2'd0, 0, 1'b0, "R5 posted hdr limit 2");
        msg(1'b0, 2'd0, 8'd44, 12'd5);       // 300 mod 256
        for (int i = 0; i < 100; i++) send(2'd0, 1024, 1'b1, "R5 posted hdr wrapped");
        send(2'd0, 0, 1'b0, "R5 posted hdr wrapped limit");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bringup();
        t_bad_class();
        t_rounding();
        t_independence();
        t_header_unit();
        t_data_wrap();
        t_hdr_wrap();
        repeat (2) @(posedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule